// File: doc/BRIEF.md
# Host Boot Mailbox Handshake Controller

This block sequences a device's bring-up against an external bus host through a single shared mailbox word. Out of reset the host side is locked, so the host can neither read nor write the block. During this phase local boot logic programs the sizes of the inbound address windows. When the local side signals that the windows are configured, the controller writes a ready code into the mailbox. On the following cycle it clears the lock, which makes the host side visible.

While unlocked, the host can read the mailbox. It can also read and rewrite the window size registers through a fixed configuration region that is always decoded. The host ends the exchange by writing a completion code into the mailbox. The controller then raises a one-cycle done pulse and a sticky done flag. From that point it ignores all further host writes. A host write of any other value is stored in the mailbox and leaves the controller waiting.

Top module: `boot_mbox_hs`

## Requirements
- R1: After reset, `lock` is 1, `hs_done` and `hs_done_pulse` are 0, and every window size field of `win_size` equals `WIN_RST` (12 by default). Field i occupies bits [i*SW +: SW].
- R2: While windows are being configured, a local write with `loc_wr_idx` below `NUM_WIN` loads `loc_wr_size` into that window one cycle later. An index of `NUM_WIN` or above changes no window.
- R3: When `win_cfg_done` is sampled high during configuration, the mailbox is loaded with 0x17171717 on that edge and `lock` falls on the next edge. The first host read of the mailbox at address `MBOX_ADDR` (0x00) while unlocked returns 0x17171717. `lock` never returns to 1.
- R4: While `lock` is 1, host writes change neither the mailbox nor any window nor `hs_done`, and `host_rdata` reads 0 for every address.
- R5: A local write in the same cycle in which `win_cfg_done` is first sampled high is kept. Local writes after that cycle are ignored.
- R6: While unlocked and not done, a host write to `MBOX_ADDR` with any value other than 0xA5A5A5A5 stores that value, reads back unchanged, and leaves `hs_done` at 0.
- R7: A host write of 0xA5A5A5A5 to `MBOX_ADDR` while waiting drives `hs_done_pulse` high for exactly the next cycle and sets `hs_done` permanently. `lock` stays 0 and the mailbox reads 0xA5A5A5A5.
- R8: While unlocked and not done, a host write to `CFG_BASE + i` (0x10 + i) for i below `NUM_WIN` loads the low `SW` bits of `host_wdata` into window i. A read of that address returns the window size zero-extended.
- R9: After `hs_done` is set, host writes to the mailbox or to the configuration region have no effect.
- R10: A host write to an address outside the mailbox and the configuration region changes nothing, and reading such an address while unlocked returns 0.
- R11: `win_cfg_done` has no effect after the ready code has been posted. The mailbox is not reloaded with the ready code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_wr_en | input | 1 | Local window size write strobe |
| loc_wr_idx | input | IW | Local window index |
| loc_wr_size | input | SW | Local window size value |
| win_cfg_done | input | 1 | Local windows configured |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | AW | Host word address for write and read |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data (combinational from `host_addr`) |
| win_size | output | NUM_WIN*SW | Current window size fields, packed |
| lock | output | 1 | Host side locked when 1 |
| hs_done | output | 1 | Sticky handshake complete |
| hs_done_pulse | output | 1 | One-cycle completion pulse |

## Verification
Two events can land on the same clock edge: the last local window write and the sampling of `win_cfg_done` that freezes the local side. The bench provokes this by driving both in one cycle. It expects the new size to appear on `win_size` and a write one cycle later to be discarded. It then checks that the mailbox reads the ready code on the first unlocked cycle, two edges after the freeze.

// File: rtl/boot_mbox_pkg.sv
package boot_mbox_pkg;

   typedef enum logic [1:0] {
      HS_CFG  = 2'd0,
      HS_REL  = 2'd1,
      HS_WAIT = 2'd2,
      HS_DONE = 2'd3
   } hs_state_t;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/bmh_seq.sv
module bmh_seq
   import boot_mbox_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic win_cfg_done,
   input  logic done_hit,
   output logic post,
   output logic cfg_open,
   output logic host_open,
   output logic lock,
   output logic hs_done,
   output logic hs_done_pulse
);

   hs_state_t st_q, st_d;
   logic      lock_q, done_q, pulse_q;
   logic      finish;

   assign post      = (st_q == HS_CFG) && win_cfg_done;
   assign cfg_open  = (st_q == HS_CFG);
   assign host_open = (st_q == HS_WAIT);
   assign finish    = host_open && done_hit;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         HS_CFG:  if (win_cfg_done) st_d = HS_REL;
         HS_REL:  st_d = HS_WAIT;
         HS_WAIT: if (done_hit) st_d = HS_DONE;
         HS_DONE: st_d = HS_DONE;
         default: st_d = HS_CFG;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= HS_CFG;
         lock_q  <= 1'b1;
         done_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         pulse_q <= finish;
         if (st_q == HS_REL) lock_q <= 1'b0;
         if (finish)         done_q <= 1'b1;
      end
   end

   assign lock          = lock_q;
   assign hs_done       = done_q;
   assign hs_done_pulse = pulse_q;

endmodule

// File: rtl/bmh_mailbox.sv
module bmh_mailbox #(
   parameter int             DW         = 32,
   parameter logic [DW-1:0]  READY_CODE = 32'h1717_1717,
   parameter logic [DW-1:0]  DONE_CODE  = 32'hA5A5_A5A5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          post,
   input  logic          host_we,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] mbox_q,
   output logic          done_hit
);

   always_ff @(posedge clk) begin
      if (!rst_n)       mbox_q <= '0;
      else if (post)    mbox_q <= READY_CODE;
      else if (host_we) mbox_q <= host_wdata;
   end

   assign done_hit = host_we && (host_wdata == DONE_CODE);

endmodule

// File: rtl/bmh_winbank.sv
module bmh_winbank #(
   parameter int NUM_WIN = 3,
   parameter int SW      = 5,
   parameter int WIN_RST = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_WIN-1:0]    loc_sel,
   input  logic [SW-1:0]         loc_size,
   input  logic [NUM_WIN-1:0]    host_sel,
   input  logic [SW-1:0]         host_size,
   output logic [NUM_WIN*SW-1:0] sizes
);

   localparam logic [SW-1:0] RST_VAL = SW'(WIN_RST);

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic [SW-1:0] sz_q;
      always_ff @(posedge clk) begin
         if (!rst_n)           sz_q <= RST_VAL;
         else if (loc_sel[w])  sz_q <= loc_size;
         else if (host_sel[w]) sz_q <= host_size;
      end
      assign sizes[w*SW +: SW] = sz_q;
   end

endmodule

// File: rtl/boot_mbox_hs.sv
module boot_mbox_hs
   import boot_mbox_pkg::*;
#(
   parameter int            DW         = 32,
   parameter int            AW         = 8,
   parameter int            NUM_WIN    = 3,
   parameter int            SW         = 5,
   parameter int            WIN_RST    = 12,
   parameter int            MBOX_ADDR  = 'h00,
   parameter int            CFG_BASE   = 'h10,
   parameter logic [DW-1:0] READY_CODE = 32'h1717_1717,
   parameter logic [DW-1:0] DONE_CODE  = 32'hA5A5_A5A5,
   localparam int           IW         = idx_width(NUM_WIN)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  loc_wr_en,
   input  logic [IW-1:0]         loc_wr_idx,
   input  logic [SW-1:0]         loc_wr_size,
   input  logic                  win_cfg_done,
   input  logic                  host_wr_en,
   input  logic [AW-1:0]         host_addr,
   input  logic [DW-1:0]         host_wdata,
   output logic [DW-1:0]         host_rdata,
   output logic [NUM_WIN*SW-1:0] win_size,
   output logic                  lock,
   output logic                  hs_done,
   output logic                  hs_done_pulse
);

   localparam longint ASPACE = longint'(1) << AW;

   if (NUM_WIN < 1) begin : g_bad_nwin
      $error("NUM_WIN must be at least 1");
   end
   if (SW < 1 || SW >= DW) begin : g_bad_sw
      $error("SW must be in 1..DW-1");
   end
   if (longint'(CFG_BASE) + NUM_WIN > ASPACE || MBOX_ADDR >= ASPACE) begin : g_bad_map
      $error("register map exceeds host address space");
   end
   if (MBOX_ADDR >= CFG_BASE && MBOX_ADDR < CFG_BASE + NUM_WIN) begin : g_bad_ovl
      $error("mailbox overlaps configuration region");
   end
   if (READY_CODE == DONE_CODE) begin : g_bad_code
      $error("ready and completion codes must differ");
   end
   if (longint'(WIN_RST) >= (longint'(1) << SW)) begin : g_bad_rst
      $error("WIN_RST does not fit in SW bits");
   end

   logic               post, cfg_open, host_open, done_hit;
   logic               mbox_hit, mbox_we, cfg_hit;
   logic [DW-1:0]      mbox_q;
   logic [NUM_WIN-1:0] loc_sel, host_hit, host_sel;
   logic [SW-1:0]      rd_size;

   assign mbox_hit = (host_addr == AW'(MBOX_ADDR));
   assign mbox_we  = host_wr_en && host_open && mbox_hit;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_dec
      assign loc_sel[w]  = loc_wr_en && cfg_open && (loc_wr_idx == IW'(w));
      assign host_hit[w] = (host_addr == AW'(CFG_BASE + w));
      assign host_sel[w] = host_wr_en && host_open && host_hit[w];
   end

   assign cfg_hit = |host_hit;

   always_comb begin
      rd_size = '0;
      for (int w = 0; w < NUM_WIN; w++) begin
         if (host_hit[w]) rd_size = rd_size | win_size[w*SW +: SW];
      end
   end

   always_comb begin
      host_rdata = '0;
      if (!lock) begin
         if (mbox_hit)     host_rdata = mbox_q;
         else if (cfg_hit) host_rdata = {{(DW-SW){1'b0}}, rd_size};
      end
   end

   bmh_seq u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .win_cfg_done  (win_cfg_done),
      .done_hit      (done_hit),
      .post          (post),
      .cfg_open      (cfg_open),
      .host_open     (host_open),
      .lock          (lock),
      .hs_done       (hs_done),
      .hs_done_pulse (hs_done_pulse)
   );

   bmh_mailbox #(
      .DW         (DW),
      .READY_CODE (READY_CODE),
      .DONE_CODE  (DONE_CODE)
   ) u_mbox (
      .clk        (clk),
      .rst_n      (rst_n),
      .post       (post),
      .host_we    (mbox_we),
      .host_wdata (host_wdata),
      .mbox_q     (mbox_q),
      .done_hit   (done_hit)
   );

   bmh_winbank #(
      .NUM_WIN (NUM_WIN),
      .SW      (SW),
      .WIN_RST (WIN_RST)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .loc_sel   (loc_sel),
      .loc_size  (loc_wr_size),
      .host_sel  (host_sel),
      .host_size (host_wdata[SW-1:0]),
      .sizes     (win_size)
   );

endmodule

// File: rtl/bmh_chk.sv
module bmh_chk #(
   parameter int            DW         = 32,
   parameter int            AW         = 8,
   parameter int            MBOX_ADDR  = 'h00,
   parameter logic [DW-1:0] READY_CODE = 32'h1717_1717,
   parameter logic [DW-1:0] DONE_CODE  = 32'hA5A5_A5A5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          lock,
   input logic          hs_done,
   input logic          hs_done_pulse,
   input logic          host_wr_en,
   input logic [AW-1:0] host_addr,
   input logic [DW-1:0] host_wdata,
   input logic [DW-1:0] mbox_q
);

   AST_LOCKED_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      lock |-> !hs_done);                                          // R1

   AST_READY_AT_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock) |-> (mbox_q == READY_CODE));                     // R3

   AST_LOCK_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      !lock |=> !lock);                                            // R3

   AST_LOCKED_WR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && host_wr_en) |=> !hs_done);                          // R4

   AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      hs_done_pulse |=> !hs_done_pulse);                           // R7

   AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      hs_done_pulse |-> (hs_done && !lock));                       // R7

   AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_done) |-> ($past(host_wr_en) && $past(host_addr) == AW'(MBOX_ADDR)
                          && $past(host_wdata) == DONE_CODE));     // R7

   AST_DONE_FREEZES_MBOX: assert property (@(posedge clk) disable iff (!rst_n)
      hs_done |=> $stable(mbox_q));                                // R9

endmodule

bind boot_mbox_hs bmh_chk #(
   .DW         (DW),
   .AW         (AW),
   .MBOX_ADDR  (MBOX_ADDR),
   .READY_CODE (READY_CODE),
   .DONE_CODE  (DONE_CODE)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .lock          (lock),
   .hs_done       (hs_done),
   .hs_done_pulse (hs_done_pulse),
   .host_wr_en    (host_wr_en),
   .host_addr     (host_addr),
   .host_wdata    (host_wdata),
   .mbox_q        (mbox_q)
);

// File: tb/sim_boot_mbox_hs.sv
`timescale 1ns/1ps
module sim_boot_mbox_hs;

   localparam int DW = 32, AW = 8, NW = 3, SW = 5, IW = 2;
   localparam logic [31:0] RDY = 32'h1717_1717;
   localparam logic [31:0] DNE = 32'hA5A5_A5A5;
   localparam int MB = 'h00, CB = 'h10;

   logic             clk = 1'b0, rst_n = 1'b0;
   logic             loc_wr_en = 1'b0, win_cfg_done = 1'b0, host_wr_en = 1'b0;
   logic [IW-1:0]    loc_wr_idx = '0;
   logic [SW-1:0]    loc_wr_size = '0;
   logic [AW-1:0]    host_addr = '0;
   logic [DW-1:0]    host_wdata = '0;
   logic [DW-1:0]    host_rdata;
   logic [NW*SW-1:0] win_size;
   logic             lock, hs_done, hs_done_pulse;

   int n_chk = 0, n_fail = 0;
   logic [SW-1:0] m_win [NW];
   logic [DW-1:0] m_mbox;
   logic          m_lock;

   always #2.5 clk = ~clk;

   boot_mbox_hs u0 (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic [AW-1:0] a);
      if (m_lock) return '0;
      if (a == AW'(MB)) return m_mbox;
      if (a >= AW'(CB) && a < AW'(CB + NW)) return {27'd0, m_win[a - AW'(CB)]};
      return '0;
   endfunction

   function automatic logic [AW-1:0] rnd_unmapped();
      logic [AW-1:0] a;
      do a = AW'($urandom); while (a == AW'(MB) || (a >= AW'(CB) && a < AW'(CB + NW)));
      return a;
   endfunction

   task automatic rd_chk(input string req, input logic [AW-1:0] a);
      host_addr = a;
      #0.5;
      chk(req, host_rdata, exp_rd(a));
   endtask

   task automatic chk_wins(input string req);
      for (int w = 0; w < NW; w++) chk(req, 32'(win_size[w*SW +: SW]), 32'(m_win[w]));
   endtask

   task automatic host_wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr_en = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr_en = 1'b0;
   endtask

   task automatic loc_wr(input logic [IW-1:0] i, input logic [SW-1:0] s, input logic cfgd);
      @(negedge clk);
      loc_wr_en = 1'b1; loc_wr_idx = i; loc_wr_size = s; win_cfg_done = cfgd;
      @(negedge clk);
      loc_wr_en = 1'b0; win_cfg_done = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int w = 0; w < NW; w++) m_win[w] = SW'(12);
      m_mbox = '0; m_lock = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 lock", 32'(lock), 1);
      chk("R1 done", 32'(hs_done), 0);
      chk("R1 pulse", 32'(hs_done_pulse), 0);
      chk_wins("R1 window reset");
      rd_chk("R1 read locked", AW'(MB));

      // R2 random local writes, out-of-range index included
      for (int k = 0; k < 30; k++) begin
         logic [IW-1:0] i;
         logic [SW-1:0] s;
         i = IW'($urandom); s = SW'($urandom);
         loc_wr(i, s, 1'b0);
         if (i < NW) m_win[i] = s;
         chk_wins("R2 local write");
      end
      loc_wr(2'd3, 5'd31, 1'b0);
      chk_wins("R2 index 3 ignored");

      // R4 host access while locked
      host_wr(AW'(MB), DNE);
      host_wr(AW'(CB + 1), 32'h1F);
      chk("R4 lock still set", 32'(lock), 1);
      chk("R4 no done", 32'(hs_done), 0);
      chk_wins("R4 windows untouched");
      rd_chk("R4 read cfg while locked", AW'(CB + 1));

      // R5 local write coinciding with configured strobe
      @(negedge clk);
      loc_wr_en = 1'b1; loc_wr_idx = 2'd1; loc_wr_size = 5'd7; win_cfg_done = 1'b1;
      @(negedge clk);
      loc_wr_en = 1'b0; win_cfg_done = 1'b0;
      m_win[1] = 5'd7;
      chk_wins("R5 same-cycle write kept");
      chk("R3 lock held one cycle after post", 32'(lock), 1);
      @(negedge clk);
      chk("R3 lock released", 32'(lock), 0);
      m_lock = 1'b0; m_mbox = RDY;
      rd_chk("R3 ready code visible", AW'(MB));
      loc_wr(2'd0, 5'd3, 1'b0);
      chk_wins("R5 late local write ignored");

      // R6/R8/R10 random host traffic while waiting
      for (int k = 0; k < 300; k++) begin
         logic [AW-1:0] a;
         logic [31:0]   d;
         int            sel;
         sel = $urandom_range(0, 2);
         do d = $urandom; while (d == DNE);
         if (sel == 0) a = AW'(MB);
         else if (sel == 1) a = AW'(CB + $urandom_range(0, NW - 1));
         else a = rnd_unmapped();
         host_wr(a, d);
         if (sel == 0) m_mbox = d;
         else if (sel == 1) m_win[a - AW'(CB)] = d[SW-1:0];
         rd_chk(sel == 0 ? "R6 mailbox readback" : (sel == 1 ? "R8 cfg readback" : "R10 unmapped read"), a);
         if (k % 25 == 0) begin
            chk_wins("R8 window state");
            rd_chk("R6 mailbox state", AW'(MB));
            chk("R6 not done", 32'(hs_done), 0);
         end
      end
      host_wr(AW'(MB), 32'h0000_0000);
      m_mbox = '0;
      rd_chk("R6 zero value", AW'(MB));
      host_wr(AW'(MB), RDY);
      m_mbox = RDY;
      chk("R6 ready code rewrite not done", 32'(hs_done), 0);

      // R11 configured strobe after post
      @(negedge clk); win_cfg_done = 1'b1;
      @(negedge clk); win_cfg_done = 1'b0;
      host_wr(AW'(MB), 32'h1234_5678);
      m_mbox = 32'h1234_5678;
      @(negedge clk); win_cfg_done = 1'b1;
      @(negedge clk); win_cfg_done = 1'b0;
      @(negedge clk);
      rd_chk("R11 mailbox not reloaded", AW'(MB));
      chk("R11 lock stays clear", 32'(lock), 0);

      // R7 completion
      host_wr(AW'(MB), DNE);
      m_mbox = DNE;
      chk("R7 pulse", 32'(hs_done_pulse), 1);
      chk("R7 done", 32'(hs_done), 1);
      chk("R7 lock", 32'(lock), 0);
      rd_chk("R7 mailbox done code", AW'(MB));
      @(negedge clk);
      chk("R7 pulse one cycle", 32'(hs_done_pulse), 0);
      chk("R7 done sticky", 32'(hs_done), 1);

      // R9 writes after completion ignored
      for (int k = 0; k < 20; k++) begin
         logic [AW-1:0] a;
         a = (k % 2 == 0) ? AW'(MB) : AW'(CB + (k % NW));
         host_wr(a, $urandom);
         rd_chk("R9 frozen readback", a);
      end
      chk_wins("R9 windows frozen");
      chk("R9 done held", 32'(hs_done), 1);
      chk("R9 no pulse", 32'(hs_done_pulse), 0);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule